// File: doc/BRIEF.md
# Interrupt Enable Delegation CSR Unit

This block holds the interrupt enable, interrupt pending and interrupt delegation state for one hart. It exposes machine-level registers and supervisor-level views of them. The supervisor enable and supervisor pending registers have no storage of their own. Each one is a window onto the machine register behind it, and the delegation register gates that window bit by bit for both reads and writes. The supervisor enable update has exactly three inputs: the current enable value, the delegation mask and the write data. No other state can feed it.

The block sits beside the CSR file. It sees one CSR access per cycle, given by a valid flag, a write flag, a 12-bit address and 64-bit data. It returns read data and an illegal-access flag in the same cycle. Hardware pending lines come in from the interrupt sources. For each privilege level the block drives the vector of interrupts that are both enabled and pending. A later stage does trap selection using these vectors.

Top module: `irq_enable_deleg`

## Requirements
- R1: After reset, the enable register, the delegation register and the software pending bit are all zero.
- R2: A legal write to address 0x304 (machine enable) replaces the enable register with the write data masked to the implemented positions 1, 3, 5, 7, 9 and 11. A read of 0x304 returns the enable register.
- R3: A legal write to address 0x303 (delegation) stores the write data masked to bits 1, 5 and 9. Every other delegation bit reads as zero.
- R4: A legal write to address 0x104 (supervisor enable) sets the new enable value to (old enable AND NOT delegation) OR (write data AND delegation). Bits that are not delegated keep their value.
- R5: A read of 0x104 returns the enable register ANDed with the delegation register.
- R6: A read of 0x344 (machine pending) returns the hardware pending inputs masked to positions 3, 5, 7, 9 and 11, ORed with the software pending bit at position 1. A read of 0x144 (supervisor pending) returns that value ANDed with the delegation register.
- R7: The software pending bit (position 1) can be written through 0x344. It can be written through 0x144 only while delegation bit 1 is set. Writes never change the hardware-driven pending bits.
- R8: Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. An access whose address bits [9:8] exceed the current privilege raises illegal_o, has no effect on state, and reads zero.
- R9: A write to any other address changes no state. A read of any other address returns zero, and so does any cycle without a valid access.
- R10: irq_m_o is pending AND enable AND NOT delegation. irq_s_o is pending AND enable AND delegation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| csr_valid_i | input | 1 | CSR access this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | Write data |
| hw_pend_i | input | 64 | Hardware pending lines from interrupt sources |
| csr_rdata_o | output | 64 | Read data |
| illegal_o | output | 1 | Privilege violation on this access |
| irq_m_o | output | 64 | Enabled and pending interrupts handled at machine level |
| irq_s_o | output | 64 | Enabled and pending interrupts delegated to supervisor level |

## Verification
The bench targets supervisor-enable writes under changing delegation masks. If a design merged write data into bits that are not delegated, or let any other register feed the update, the enable register would drift away from the model. Supervisor-pending writes are sent both with and without delegation of the software bit, so a design that latched the bit regardless would be caught. Accesses from too low a privilege and writes to unrelated addresses are mixed into the random traffic, so any write leaking through a guard shows up as a mismatch on the next read or interrupt vector.

// File: rtl/irq_enable_deleg.sv
module irq_enable_deleg #(
  parameter int          XLEN        = 64,
  parameter logic [63:0] IMPL_MASK   = 64'hAAA,
  parameter logic [63:0] DELEG_MASK  = 64'h222,
  parameter logic [63:0] SWPEND_MASK = 64'h002
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv_i,
  input  logic            csr_valid_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [XLEN-1:0] hw_pend_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] irq_m_o,
  output logic [XLEN-1:0] irq_s_o
);
  localparam logic [11:0] A_MIE = 12'h304;
  localparam logic [11:0] A_MDL = 12'h303;
  localparam logic [11:0] A_MIP = 12'h344;
  localparam logic [11:0] A_SIE = 12'h104;
  localparam logic [11:0] A_SIP = 12'h144;
  localparam logic [XLEN-1:0] IMPL  = IMPL_MASK[XLEN-1:0];
  localparam logic [XLEN-1:0] DMSK  = DELEG_MASK[XLEN-1:0];
  localparam logic [XLEN-1:0] SWMSK = SWPEND_MASK[XLEN-1:0];

  logic [XLEN-1:0] en_q, en_d, dl_q, dl_d, sw_q, sw_d, pend;
  logic            wr;

  assign illegal_o = csr_valid_i && (csr_addr_i[9:8] > priv_i);
  assign wr        = csr_valid_i && csr_we_i && !illegal_o;
  assign pend      = (hw_pend_i & IMPL & ~SWMSK) | sw_q;
  assign irq_m_o   = pend & en_q & ~dl_q;
  assign irq_s_o   = pend & en_q & dl_q;

  always_comb begin
    en_d = en_q;
    dl_d = dl_q;
    sw_d = sw_q;
    if (wr) begin
      case (csr_addr_i)
        A_MIE:   en_d = csr_wdata_i & IMPL;
        A_SIE:   en_d = (en_q & ~dl_q) | (csr_wdata_i & dl_q);
        A_MDL:   dl_d = csr_wdata_i & DMSK;
        A_MIP:   sw_d = csr_wdata_i & SWMSK;
        A_SIP:   sw_d = (sw_q & ~dl_q) | (csr_wdata_i & dl_q & SWMSK);
        default: ;
      endcase
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_valid_i && !illegal_o) begin
      case (csr_addr_i)
        A_MIE:   csr_rdata_o = en_q;
        A_MDL:   csr_rdata_o = dl_q;
        A_MIP:   csr_rdata_o = pend;
        A_SIE:   csr_rdata_o = en_q & dl_q;
        A_SIP:   csr_rdata_o = pend & dl_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      dl_q <= '0;
      sw_q <= '0;
    end else begin
      en_q <= en_d;
      dl_q <= dl_d;
      sw_q <= sw_d;
    end
  end

  p_sie_keeps_undelegated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && csr_addr_i == A_SIE) |=> (((en_q ^ $past(en_q)) & ~$past(dl_q)) == '0));

  p_illegal_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> ($stable(en_q) && $stable(dl_q) && $stable(sw_q)));

  p_unmapped_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid_i && csr_addr_i != A_MIE && csr_addr_i != A_SIE && csr_addr_i != A_MDL &&
     csr_addr_i != A_MIP && csr_addr_i != A_SIP) |=> ($stable(en_q) && $stable(dl_q) && $stable(sw_q)));

  p_deleg_legal_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_q & ~DMSK) == '0);

  p_enable_legal_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~IMPL) == '0);

  p_irq_disjoint_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_m_o & irq_s_o) == '0);

  p_sip_guarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && csr_addr_i == A_SIP && !dl_q[1]) |=> $stable(sw_q));
endmodule

// File: tb/irq_enable_deleg_tb.sv
module irq_enable_deleg_tb;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  priv = 3;
  logic        vld = 0, we = 0;
  logic [11:0] addr = 0;
  logic [63:0] wd = 0, hw = 0;
  logic [63:0] rdata, irq_m, irq_s;
  logic        ill;
  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_en = 0, m_dl = 0, m_sw = 0;

  always #4 clk = ~clk;

  irq_enable_deleg u_dut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .csr_valid_i(vld), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wd), .hw_pend_i(hw), .csr_rdata_o(rdata),
    .illegal_o(ill), .irq_m_o(irq_m), .irq_s_o(irq_s));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h priv=%0d actual=%h expected=%h", tag, addr, priv, act, exp);
    end
  endtask

  function automatic logic [63:0] m_pend();
    return (hw & 64'hAA8) | m_sw;
  endfunction

  function automatic bit m_illegal();
    int lvl = int'(addr[9:8]);
    return vld && (lvl > int'(priv));
  endfunction

  // one access: inputs set at negedge, outputs checked before the edge, model advanced
  task automatic acc(bit v, bit w, logic [11:0] a, logic [63:0] d, logic [1:0] p,
                     logic [63:0] h, output logic [63:0] got);
    logic [63:0] exp_rd, n_en, n_dl, n_sw;
    string tag;
    bit il;
    vld = v; we = w; addr = a; wd = d; priv = p; hw = h;
    #1;
    il = m_illegal();
    exp_rd = 0; tag = "R9";
    n_en = m_en; n_dl = m_dl; n_sw = m_sw;
    case (a)
      12'h304: begin tag = "R2"; exp_rd = m_en; end
      12'h303: begin tag = "R3"; exp_rd = m_dl; end
      12'h344: begin tag = "R6"; exp_rd = m_pend(); end
      12'h104: begin tag = "R5"; exp_rd = m_en & m_dl; end
      12'h144: begin tag = "R6"; exp_rd = m_pend() & m_dl; end
      default: ;
    endcase
    if (!v || il) exp_rd = 0;
    chk("R8", {63'b0, ill}, {63'b0, il});
    chk(tag, rdata, exp_rd);
    chk("R10", irq_m, m_pend() & m_en & ~m_dl);
    chk("R10", irq_s, m_pend() & m_en & m_dl);
    got = rdata;
    if (v && w && !il) begin
      if (a == 12'h304) n_en = d & 64'hAAA;
      if (a == 12'h303) n_dl = d & 64'h222;
      if (a == 12'h344) n_sw = d & 64'h2;
      if (a == 12'h104)
        for (int b = 0; b < 64; b++) if (m_dl[b]) n_en[b] = d[b];
      if (a == 12'h144 && m_dl[1]) n_sw = d & 64'h2;
    end
    @(posedge clk);
    m_en = n_en; m_dl = n_dl; m_sw = n_sw;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] got);
    acc(1, 0, a, 64'h0, 2'd3, hw, got);
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d, logic [1:0] p);
    logic [63:0] g;
    acc(1, 1, a, d, p, hw, g);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [63:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(12'h304, g); chk("R1", g, 64'h0);
    rd(12'h303, g); chk("R1", g, 64'h0);
    rd(12'h344, g); chk("R1", g, 64'h0);

    wr(12'h304, {64{1'b1}}, 3); rd(12'h304, g); chk("R2", g, 64'hAAA);
    wr(12'h303, {64{1'b1}}, 3); rd(12'h303, g); chk("R3", g, 64'h222);
    wr(12'h104, 64'h0, 3);      rd(12'h304, g); chk("R4", g, 64'h888);
    wr(12'h104, 64'h20, 1);     rd(12'h104, g); chk("R5", g, 64'h020);
    wr(12'h303, 64'h0, 1);      rd(12'h303, g); chk("R8", g, 64'h222);
    wr(12'h104, 64'h0, 0);      rd(12'h304, g); chk("R8", g, 64'h8A8);
    wr(12'h303, 64'h200, 3);
    wr(12'h144, 64'h2, 1);      rd(12'h344, g); chk("R7", g & 64'h2, 64'h0);
    wr(12'h344, 64'h2, 3);      rd(12'h344, g); chk("R7", g & 64'h2, 64'h2);
    wr(12'h303, 64'h2, 3);
    wr(12'h144, 64'h0, 1);      rd(12'h344, g); chk("R7", g & 64'h2, 64'h0);
    wr(12'h305, {64{1'b1}}, 3); rd(12'h304, g); chk("R9", g, 64'h8A8);
    wr(12'h340, {64{1'b1}}, 3); rd(12'h304, g); chk("R9", g, 64'h8A8);

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [1:0]  p;
      case ($urandom % 7)
        0: a = 12'h304; 1: a = 12'h303; 2: a = 12'h344;
        3: a = 12'h104; 4: a = 12'h144; 5: a = 12'h104;
        default: a = 12'($urandom);
      endcase
      case ($urandom % 3) 0: p = 0; 1: p = 1; default: p = 3; endcase
      acc(($urandom % 8) != 0, $urandom % 2 == 1, a, r64(), p, r64(), g);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule